// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver with Handshake

This block moves one byte at a time over a three-wire synchronous link: a shift clock, a transmit line and a receive line. Every frame transmits and receives at the same time, so a byte is received by queuing a byte to send, which may be a dummy. The host writes bytes into a one-entry transmit holding register. From there they pass into a transmit shifter. Received bytes land in a one-entry receive holding register. Status flags and two sticky interrupt requests report progress. An active-low clear-to-send input pauses transmission at frame boundaries. An active-low ready-to-receive output tells the peer when a frame may be clocked in.

The shift clock comes from one of two places. In the default mode an on-chip divider derives it from the system clock, through a selectable prescaler and an 8-bit divisor. Otherwise the peer drives it on `sclk_in`, which is synchronized and edge-detected inside the block. Polarity is fixed: the clock idles high, the transmit line changes on the falling edge, and the receive line is sampled on the rising edge.

Top module: `sync_serial_xcvr`

## Requirements
- R1: In internal mode each half period of `sclk_out` lasts (cfg_div+1)*P system clocks, so the full period is 2*(cfg_div+1)*P. P is 1, 8 or 32 for `cfg_src` 0, 1 or 2, and `cfg_src` 3 also gives 32.
- R2: A frame carries 8 bits, least significant first. `txd` changes on the falling shift-clock edge and `rxd` is sampled on the rising edge. `sclk_out` is high whenever no frame is active. In internal mode, `rxd` must be stable from two system clocks after the falling edge until the rising edge.
- R3: `wr_tx` clears `tx_buf_empty` on the next clock. The flag sets again when the byte moves into the shifter. A byte written during a frame follows it with no idle clock period.
- R4: `tx_reg_empty` is low from the moment a byte is loaded until the last bit ends. It rises only if no further byte is loaded at that boundary.
- R5: A frame starts, or continues into a queued byte, only while `tx_en` is 1 and the synchronized `cts_n` is 0. Otherwise the clock stays high and the byte waits until both conditions allow it.
- R6: `tx_irq` sets when a byte leaves the transmit holding register and stays set until `tx_irq_clr` is pulsed.
- R7: With `cfg_ext_clk`=1, a frame starts only while `sclk_in` is high, `tx_en` is 1 and a byte is queued. Bits shift on the synchronized edges of `sclk_in`, which must run at no more than a quarter of the system clock. `sclk_out` stays high in this mode.
- R8: When the eighth bit completes with `rx_en`=1, `rx_data` takes the received byte and `rx_full` and `rx_irq` set on that edge. `rx_irq` clears on `rx_irq_clr`. With `rx_en`=0, `rx_data` and `rx_full` are left unchanged.
- R9: `rd_rx` clears `rx_full` and `rx_overrun` on the next clock.
- R10: A byte that completes while `rx_full` is set overwrites `rx_data` and sets `rx_overrun`.
- R11: `rts_n` is low exactly when `rx_en` and `tx_en` are 1, a byte is queued, `rx_full` is 0 and no frame is active. It is high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ext_clk | input | 1 | 1 selects the shift clock from `sclk_in` |
| cfg_src | input | 2 | Prescaler select for the internal divider |
| cfg_div | input | 8 | Divisor value n |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| wr_tx | input | 1 | Write strobe for the transmit holding register |
| wr_data | input | 8 | Byte to transmit |
| rd_rx | input | 1 | Read strobe for the receive holding register |
| rx_data | output | 8 | Receive holding register contents |
| tx_irq_clr | input | 1 | Clears the transmit request |
| rx_irq_clr | input | 1 | Clears the receive request |
| tx_buf_empty | output | 1 | Transmit holding register empty |
| tx_reg_empty | output | 1 | Transmit shifter idle |
| rx_full | output | 1 | Unread received byte present |
| rx_overrun | output | 1 | A byte was overwritten unread |
| tx_irq | output | 1 | Transmit interrupt request |
| rx_irq | output | 1 | Receive interrupt request |
| sclk_in | input | 1 | Shift clock from the peer |
| sclk_out | output | 1 | Internally generated shift clock |
| txd | output | 1 | Serial transmit data |
| rxd | input | 1 | Serial receive data |
| cts_n | input | 1 | Clear to send, active low |
| rts_n | output | 1 | Ready to receive, active low |

## Verification
A write shows in `tx_buf_empty` one clock later. The shifter load follows one clock after that, so `tx_irq` and `tx_reg_empty` are checked two clocks after the write strobe. In internal mode, `txd` and the receive flags change on the same system edge as the matching `sclk_out` edge. The bench therefore waits for the observed `sclk_out` transition and samples at the following falling system edge. Edges on `sclk_in` take about three clocks to act, so the bench holds each external clock level for eight clocks and samples just before the next pin change. Handshake and gating checks wait at least two clocks after a `cts_n` change, to cover the synchronizer.

// File: rtl/ssx_pkg.sv
package ssx_pkg;
   typedef enum logic [1:0] {
      SRC_FAST = 2'd0,
      SRC_MID  = 2'd1,
      SRC_SLOW = 2'd2,
      SRC_ALT  = 2'd3
   } ssx_src_e;
endpackage

// File: rtl/ssx_sync.sv
module ssx_sync #(
   parameter int W = 3,
   parameter int STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   localparam int CHAIN_W = W * STAGES;

   initial assert (STAGES >= 2) else $fatal(1, "ssx_sync needs two or more stages");

   logic [CHAIN_W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[CHAIN_W-W-1:0], d};
   end

   assign q = chain[CHAIN_W-1 -: W];
endmodule

// File: rtl/ssx_baud.sv
module ssx_baud
   import ssx_pkg::*;
#(
   parameter int DIV_W = 8,
   parameter int PRE_MID = 8,
   parameter int PRE_HI = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  ssx_src_e         src,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   localparam int PW = (PRE_HI > 1) ? $clog2(PRE_HI) : 1;

   initial assert (PRE_HI >= PRE_MID && PRE_MID >= 1) else $fatal(1, "ssx_baud prescaler order");

   logic [PW-1:0]    pre_cnt, pre_lim;
   logic [DIV_W-1:0] div_cnt;
   logic             pre_tick;

   always_comb begin
      case (src)
         SRC_FAST: pre_lim = '0;
         SRC_MID:  pre_lim = PW'(PRE_MID - 1);
         default:  pre_lim = PW'(PRE_HI - 1);
      endcase
   end

   assign pre_tick = run && (pre_cnt == pre_lim);
   assign tick     = pre_tick && (div_cnt == div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_cnt <= '0;
         div_cnt <= '0;
      end else if (!run) begin
         pre_cnt <= '0;
         div_cnt <= '0;
      end else begin
         pre_cnt <= pre_tick ? '0 : pre_cnt + 1'b1;
         if (pre_tick) div_cnt <= tick ? '0 : div_cnt + 1'b1;
      end
   end

   // R1: the divisor counter never passes the programmed limit while running
   assert_div_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
      run && $stable(div) && $past(run) |-> div_cnt <= div);
endmodule

// File: rtl/ssx_core.sv
module ssx_core #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ext_mode,
   input  logic          tx_en,
   input  logic          rx_en,
   input  logic          wr_tx,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_rx,
   input  logic          tx_irq_clr,
   input  logic          rx_irq_clr,
   input  logic          tick,
   input  logic          sclk_s,
   input  logic          cts_s,
   input  logic          rxd_s,
   output logic          run,
   output logic          sclk_out,
   output logic          txd,
   output logic          rts_n,
   output logic [DW-1:0] rx_data,
   output logic          tx_buf_empty,
   output logic          tx_reg_empty,
   output logic          rx_full,
   output logic          rx_overrun,
   output logic          tx_irq,
   output logic          rx_irq
);
   localparam int CW = $clog2(DW);

   initial assert (DW >= 2) else $fatal(1, "ssx_core frame too short");

   logic          buf_full, act, ph, sclk_q, txd_q, sclk_d, ovr_q, full_q;
   logic          tirq_q, rirq_q;
   logic [DW-1:0] tx_buf, tx_sh, rx_sh, rx_buf;
   logic [CW-1:0] bcnt;
   logic          line_ok, load, ev_fall, ev_rise, last;
   logic [DW-1:0] rx_next;

   assign line_ok = tx_en && !cts_s && (!ext_mode || sclk_s);
   assign ev_fall = act && (ext_mode ? (sclk_d && !sclk_s) : (tick && !ph));
   assign ev_rise = act && (ext_mode ? (!sclk_d && sclk_s) : (tick && ph));
   assign last    = ev_rise && (bcnt == CW'(DW - 1));
   assign load    = buf_full && line_ok && (!act || last);
   assign rx_next = {rxd_s, rx_sh[DW-1:1]};
   assign run     = act && !ext_mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_full <= 1'b0;  act    <= 1'b0;  ph     <= 1'b0;
         sclk_q   <= 1'b1;  txd_q  <= 1'b1;  sclk_d <= 1'b1;
         ovr_q    <= 1'b0;  full_q <= 1'b0;  tirq_q <= 1'b0;
         rirq_q   <= 1'b0;  bcnt   <= '0;
         tx_buf   <= '0;    tx_sh  <= '0;    rx_sh  <= '0;   rx_buf <= '0;
      end else begin
         sclk_d <= sclk_s;
         if (ev_fall) begin
            sclk_q <= ext_mode;
            txd_q  <= tx_sh[0];
            ph     <= 1'b1;
         end
         if (ev_rise) begin
            sclk_q <= 1'b1;
            ph     <= 1'b0;
            tx_sh  <= tx_sh >> 1;
            rx_sh  <= rx_next;
            bcnt   <= bcnt + 1'b1;
         end
         if (tx_irq_clr) tirq_q <= 1'b0;
         if (rx_irq_clr) rirq_q <= 1'b0;
         if (rd_rx) begin
            full_q <= 1'b0;
            ovr_q  <= 1'b0;
         end
         if (last) begin
            act  <= 1'b0;
            bcnt <= '0;
            if (rx_en) begin
               rx_buf <= rx_next;
               full_q <= 1'b1;
               ovr_q  <= ovr_q && !rd_rx || full_q && !rd_rx;
               rirq_q <= 1'b1;
            end
         end
         if (load) begin
            tx_sh    <= tx_buf;
            buf_full <= 1'b0;
            act      <= 1'b1;
            ph       <= 1'b0;
            bcnt     <= '0;
            tirq_q   <= 1'b1;
         end
         if (wr_tx) begin
            tx_buf   <= wr_data;
            buf_full <= 1'b1;
         end
      end
   end

   assign sclk_out     = sclk_q;
   assign txd          = txd_q;
   assign rx_data      = rx_buf;
   assign tx_buf_empty = !buf_full;
   assign tx_reg_empty = !act;
   assign rx_full      = full_q;
   assign rx_overrun   = ovr_q;
   assign tx_irq       = tirq_q;
   assign rx_irq       = rirq_q;
   assign rts_n        = !(rx_en && tx_en && buf_full && !full_q && !act);

   assert_bitcount_R2: assert property (@(posedge clk) disable iff (!rst_n)
      act |-> bcnt <= CW'(DW - 1));
   assert_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tx_reg_empty |-> sclk_out);
   assert_write_fills_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_tx |=> !tx_buf_empty);
   assert_start_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_reg_empty) |-> $past(tx_en && !cts_s));
   assert_ext_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_reg_empty) && $past(ext_mode) |-> $past(sclk_s));
   assert_rx_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_full) |-> rx_irq);
   assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_rx && !last |=> !rx_full && !rx_overrun);
   assert_overrun_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_overrun) |-> rx_full);
endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr
   import ssx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DIV_W = 8,
   parameter int PRE_MID = 8,
   parameter int PRE_HI = 32,
   parameter int SYNC_STAGES = 2,
   parameter bit EXT_CLK_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_ext_clk,
   input  logic [1:0]        cfg_src,
   input  logic [DIV_W-1:0]  cfg_div,
   input  logic              tx_en,
   input  logic              rx_en,
   input  logic              wr_tx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_rx,
   output logic [DATA_W-1:0] rx_data,
   input  logic              tx_irq_clr,
   input  logic              rx_irq_clr,
   output logic              tx_buf_empty,
   output logic              tx_reg_empty,
   output logic              rx_full,
   output logic              rx_overrun,
   output logic              tx_irq,
   output logic              rx_irq,
   input  logic              sclk_in,
   output logic              sclk_out,
   output logic              txd,
   input  logic              rxd,
   input  logic              cts_n,
   output logic              rts_n
);
   logic [2:0] pins_s;
   logic       ext_mode, tick, run;

   ssx_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({sclk_in, cts_n, rxd}), .q(pins_s)
   );

   generate
      if (EXT_CLK_EN) begin : g_ext
         assign ext_mode = cfg_ext_clk;
      end else begin : g_int_only
         logic unused_ext;
         assign unused_ext = cfg_ext_clk;
         assign ext_mode   = 1'b0;
      end
   endgenerate

   ssx_baud #(.DIV_W(DIV_W), .PRE_MID(PRE_MID), .PRE_HI(PRE_HI)) u_baud (
      .clk(clk), .rst_n(rst_n), .run(run), .src(ssx_src_e'(cfg_src)),
      .div(cfg_div), .tick(tick)
   );

   ssx_core #(.DW(DATA_W)) u_core (
      .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .tx_en(tx_en),
      .rx_en(rx_en), .wr_tx(wr_tx), .wr_data(wr_data), .rd_rx(rd_rx),
      .tx_irq_clr(tx_irq_clr), .rx_irq_clr(rx_irq_clr), .tick(tick),
      .sclk_s(pins_s[2]), .cts_s(pins_s[1]), .rxd_s(pins_s[0]), .run(run),
      .sclk_out(sclk_out), .txd(txd), .rts_n(rts_n), .rx_data(rx_data),
      .tx_buf_empty(tx_buf_empty), .tx_reg_empty(tx_reg_empty),
      .rx_full(rx_full), .rx_overrun(rx_overrun), .tx_irq(tx_irq),
      .rx_irq(rx_irq)
   );
endmodule

// File: tb/sync_serial_xcvr_bench.sv
module sync_serial_xcvr_bench;
   logic       clk = 1'b0, rst_n = 1'b0;
   logic       cfg_ext_clk = 1'b0, tx_en = 1'b1, rx_en = 1'b1;
   logic [1:0] cfg_src = 2'd0;
   logic [7:0] cfg_div = 8'd3, wr_data = 8'h00, rx_data;
   logic       wr_tx = 1'b0, rd_rx = 1'b0, tx_irq_clr = 1'b0, rx_irq_clr = 1'b0;
   logic       tx_buf_empty, tx_reg_empty, rx_full, rx_overrun, tx_irq, rx_irq;
   logic       sclk_in = 1'b1, sclk_out, txd, rxd = 1'b1, cts_n = 1'b0, rts_n;
   int         tests = 0, fails = 0, cyc = 0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   sync_serial_xcvr u_sync_serial_xcvr (
      .clk(clk), .rst_n(rst_n), .cfg_ext_clk(cfg_ext_clk), .cfg_src(cfg_src),
      .cfg_div(cfg_div), .tx_en(tx_en), .rx_en(rx_en), .wr_tx(wr_tx),
      .wr_data(wr_data), .rd_rx(rd_rx), .rx_data(rx_data),
      .tx_irq_clr(tx_irq_clr), .rx_irq_clr(rx_irq_clr),
      .tx_buf_empty(tx_buf_empty), .tx_reg_empty(tx_reg_empty),
      .rx_full(rx_full), .rx_overrun(rx_overrun), .tx_irq(tx_irq),
      .rx_irq(rx_irq), .sclk_in(sclk_in), .sclk_out(sclk_out), .txd(txd),
      .rxd(rxd), .cts_n(cts_n), .rts_n(rts_n)
   );

   function automatic int exp_period(input int n, input int src);
      int p;
      p = (src == 0) ? 1 : (src == 1) ? 8 : 32;
      return 2 * (n + 1) * p;
   endfunction

   task automatic chk(input string req, input int actual, input int expected);
      tests++;
      if (actual !== expected) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic put(input logic [7:0] b);
      wr_data = b; wr_tx = 1'b1; @(negedge clk); wr_tx = 1'b0;
   endtask

   task automatic get();
      rd_rx = 1'b1; @(negedge clk); rd_rx = 1'b0;
   endtask

   task automatic wait_lvl(input logic lvl, output int t);
      bit seen = 1'b0;
      for (int k = 0; k < 20000 && !seen; k++) begin
         @(negedge clk);
         if (sclk_out === lvl) seen = 1'b1;
      end
      t = cyc;
      if (!seen) chk("R2 shift clock timeout", 0, 1);
   endtask

   task automatic int_frame(input logic [7:0] rxb, output logic [7:0] got, output int per);
      int t0 = 0, t1 = 0;
      per = 0;
      for (int i = 0; i < 8; i++) begin
         wait_lvl(1'b0, t1);
         if (i == 0) t0 = t1;
         if (i == 1) per = t1 - t0;
         rxd = rxb[i];
         wait_lvl(1'b1, t1);
         got[i] = txd;
      end
   endtask

   task automatic ext_frame(input logic [7:0] rxb, output logic [7:0] got);
      for (int i = 0; i < 8; i++) begin
         sclk_in = 1'b0; rxd = rxb[i]; idle(8);
         got[i] = txd;
         sclk_in = 1'b1; idle(8);
      end
   endtask

   initial begin
      int per;
      logic [7:0] got, b1, b2, r1, r2, hold;
      void'($urandom(32'd2024));
      idle(3);
      chk("R3 reset tx_buf_empty", int'(tx_buf_empty), 1);
      chk("R4 reset tx_reg_empty", int'(tx_reg_empty), 1);
      chk("R8 reset rx_full", int'(rx_full), 0);
      chk("R2 reset sclk_out", int'(sclk_out), 1);
      chk("R11 reset rts_n", int'(rts_n), 1);
      rst_n = 1'b1; idle(3);

      // R1 R2 R8: random divisor, prescaler and data
      for (int k = 0; k < 6; k++) begin
         int n = 2 + int'($urandom % 5);
         int s = int'($urandom % 3);
         b1 = 8'($urandom); r1 = 8'($urandom);
         cfg_div = 8'(n); cfg_src = 2'(s);
         put(b1);
         int_frame(r1, got, per);
         chk("R1 period", per, exp_period(n, s));
         chk("R2 tx bits lsb first", int'(got), int'(b1));
         chk("R8 rx_full", int'(rx_full), 1);
         chk("R8 rx_irq", int'(rx_irq), 1);
         chk("R8 rx_data", int'(rx_data), int'(r1));
         chk("R4 idle after frame", int'(tx_reg_empty), 1);
         get();
         rx_irq_clr = 1'b1; tx_irq_clr = 1'b1; @(negedge clk);
         rx_irq_clr = 1'b0; tx_irq_clr = 1'b0;
         chk("R8 rx_irq cleared", int'(rx_irq), 0);
         chk("R9 rx_full cleared", int'(rx_full), 0);
      end

      // R1: reserved prescaler code acts as the slow one
      cfg_src = 2'd3; cfg_div = 8'd0;
      put(8'h5A); int_frame(8'h00, got, per);
      chk("R1 reserved prescaler", per, exp_period(0, 2));
      get();
      cfg_src = 2'd0; cfg_div = 8'd3;

      // R3 R4 R6 R10 R9: queued second byte, overrun
      b1 = 8'hC3; b2 = 8'h96; r1 = 8'h1E; r2 = 8'hE1;
      tx_irq_clr = 1'b1; @(negedge clk); tx_irq_clr = 1'b0;
      put(b1);
      chk("R3 write clears empty", int'(tx_buf_empty), 0);
      @(negedge clk);
      chk("R3 load sets empty", int'(tx_buf_empty), 1);
      chk("R4 shifting", int'(tx_reg_empty), 0);
      chk("R6 tx_irq set", int'(tx_irq), 1);
      tx_irq_clr = 1'b1; @(negedge clk); tx_irq_clr = 1'b0;
      chk("R6 tx_irq cleared", int'(tx_irq), 0);
      put(b2);
      int_frame(r1, got, per);
      chk("R3 first byte", int'(got), int'(b1));
      chk("R4 reloaded no gap", int'(tx_reg_empty), 0);
      chk("R3 second moved", int'(tx_buf_empty), 1);
      int_frame(r2, got, per);
      chk("R3 second byte", int'(got), int'(b2));
      chk("R3 no idle period", per, exp_period(3, 0));
      chk("R4 idle at end", int'(tx_reg_empty), 1);
      chk("R10 overrun set", int'(rx_overrun), 1);
      chk("R10 data overwritten", int'(rx_data), int'(r2));
      get();
      chk("R9 overrun cleared", int'(rx_overrun), 0);
      chk("R9 full cleared", int'(rx_full), 0);

      // R5 R11: clear-to-send gating and ready-to-receive
      chk("R11 rts high when nothing queued", int'(rts_n), 1);
      cts_n = 1'b1; idle(3);
      put(8'hA7); idle(40);
      chk("R5 held by cts: tx_reg_empty", int'(tx_reg_empty), 1);
      chk("R5 held by cts: sclk_out", int'(sclk_out), 1);
      chk("R11 rts low when ready", int'(rts_n), 0);
      cts_n = 1'b0;
      int_frame(8'h3C, got, per);
      chk("R5 resumed data", int'(got), 32'hA7);
      cts_n = 1'b1; idle(3);
      put(8'h11); idle(3);
      chk("R11 rts high with rx_full", int'(rts_n), 1);
      get();
      chk("R11 rts low after read", int'(rts_n), 0);
      tx_en = 1'b0; cts_n = 1'b0; idle(40);
      chk("R5 held by tx_en", int'(tx_reg_empty), 1);
      chk("R11 rts high with tx_en 0", int'(rts_n), 1);
      tx_en = 1'b1;
      int_frame(8'h00, got, per);
      chk("R5 resumed after tx_en", int'(got), 32'h11);
      get();

      // R8: receive disabled leaves buffer alone
      hold = rx_data; rx_en = 1'b0;
      put(8'h42); int_frame(8'hFF, got, per);
      idle(2);
      chk("R8 rx_en 0 no full", int'(rx_full), 0);
      chk("R8 rx_en 0 data kept", int'(rx_data), int'(hold));
      rx_en = 1'b1;

      // R7: external clock mode
      cfg_ext_clk = 1'b1; sclk_in = 1'b0; idle(4);
      b1 = 8'h6D; r1 = 8'hB2;
      put(b1); idle(10);
      chk("R7 waits for clock high", int'(tx_reg_empty), 1);
      sclk_in = 1'b1; idle(8);
      chk("R7 started", int'(tx_reg_empty), 0);
      ext_frame(r1, got);
      chk("R7 tx data", int'(got), int'(b1));
      chk("R7 rx data", int'(rx_data), int'(r1));
      chk("R7 rx_full", int'(rx_full), 1);
      chk("R7 sclk_out idle", int'(sclk_out), 1);
      chk("R7 frame done", int'(tx_reg_empty), 1);
      get();

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      tests++; fails++;
      $display("FAIL watchdog R2 actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule